// File: doc/BRIEF.md
# Decimal Accumulator with Digit Shifter

This block is the accumulator register of a small decimal teaching processor. It holds a signed value in sign-magnitude form. The magnitude is a row of 4-bit BCD digits, and the sign is a single flag bit. The register is one digit wider than a memory word. That top digit catches the carry-out of a word-sized result, so an overflow stays visible instead of being lost.

Around the register sit a loader and a digit shifter. The loader accepts a new sign and magnitude. The shifter moves the magnitude by whole decimal digits: a left move multiplies by a power of ten and a right move divides by one. A single shift command carries two counts. The left count is applied first and the right count second, so the pair can isolate a digit or truncate a value.

The block also drives a negative flag for a branch-if-below-zero instruction. A zero magnitude is always stored as positive zero, so the flag never reports a negative zero.

Top module: `dec_accum`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the register to positive zero with `acc_neg` low, and it takes priority over any operation presented in the same cycle.
- R2: With `en` high and `op` = 2'b01 (load), the next edge stores `ld_sign` and all `ld_mag` digits. Digit i occupies bits [4i+3:4i], with digit 0 the least significant.
- R3: During a load, any digit code above 9 is stored as 9. Every stored digit is therefore in the range 0 to 9.
- R4: With `en` high and `op` = 2'b10 (shift), a left count n multiplies the magnitude by 10^n. Zero digits enter at the bottom, digits moved past the top (overflow) digit are lost, and the sign is kept.
- R5: In a shift, a right count n divides the magnitude by 10^n, truncating. Zero digits enter at the top and digits moved below digit 0 are lost.
- R6: In one shift command the left count is applied before the right count.
- R7: A shift count equal to or larger than the number of register digits clears the magnitude. Counts run from 0 to 15.
- R8: Whenever a load or shift produces a zero magnitude, the stored sign is positive, whatever sign was requested or held.
- R9: `acc_neg` is high exactly when the stored sign is negative, which by R8 implies a nonzero magnitude.
- R10: With `en` low, or with `op` = 2'b00 or 2'b11, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to positive zero |
| en | input | 1 | Operation enable |
| op | input | 2 | 00 hold, 01 load, 10 shift, 11 hold |
| ld_sign | input | 1 | Sign to load, 1 = negative |
| ld_mag | input | 4*(WORD_DIGITS+1) | BCD magnitude to load |
| shl_cnt | input | CNT_W | Left digit-shift count |
| shr_cnt | input | CNT_W | Right digit-shift count |
| acc_sign | output | 1 | Stored sign |
| acc_mag | output | 4*(WORD_DIGITS+1) | Stored BCD magnitude |
| acc_neg | output | 1 | Accumulator below zero |

## Verification
The bench uses the default parameters: a three-digit word, which gives a four-digit register, and 4-bit shift counts. With these settings, counts from 4 to 15 exceed the register width. This reaches both shifter branches: the log stage that slides the register partly, and the stage whose step covers the whole register and simply clears it. The small register also lets short vector sequences push a digit out of the overflow position and create zero results of either sign.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_SHIFT = 2'b10,
        OP_RSVD  = 2'b11
    } acc_op_e;

    localparam int DIGIT_W = 4;

    function automatic logic [DIGIT_W-1:0] bcd_sat(input logic [DIGIT_W-1:0] d);
        return (d > 4'd9) ? 4'd9 : d;
    endfunction

endpackage

// File: rtl/bcd_load_clamp.sv
module bcd_load_clamp #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] raw_mag,
    output logic [4*DIGITS-1:0] clean_mag
);
    import dacc_pkg::*;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign clean_mag[4*g +: 4] = bcd_sat(raw_mag[4*g +: 4]);
    end

endmodule

// File: rtl/bcd_digit_shift.sv
module bcd_digit_shift #(
    parameter int DIGITS     = 4,
    parameter int CNT_W      = 4,
    parameter bit SHIFT_LEFT = 1'b1
) (
    input  logic [4*DIGITS-1:0] din,
    input  logic [CNT_W-1:0]    cnt,
    output logic [4*DIGITS-1:0] dout
);
    localparam int W = 4 * DIGITS;

    logic [W-1:0] stage [0:CNT_W];

    assign stage[0] = din;

    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        if (STEP >= DIGITS) begin : g_clear
            assign stage[s+1] = cnt[s] ? '0 : stage[s];
        end else if (SHIFT_LEFT) begin : g_left
            assign stage[s+1] = cnt[s] ? {stage[s][W-1-4*STEP:0], {(4*STEP){1'b0}}}
                                       : stage[s];
        end else begin : g_right
            assign stage[s+1] = cnt[s] ? {{(4*STEP){1'b0}}, stage[s][W-1:4*STEP]}
                                       : stage[s];
        end
    end

    assign dout = stage[CNT_W];

endmodule

// File: rtl/sign_mag_norm.sv
module sign_mag_norm #(
    parameter int MAG_W = 16
) (
    input  logic             sign_in,
    input  logic [MAG_W-1:0] mag_in,
    output logic             sign_out
);
    assign sign_out = sign_in & (|mag_in);

endmodule

// File: rtl/dec_accum.sv
module dec_accum #(
    parameter int WORD_DIGITS = 3,
    parameter int CNT_W       = 4,
    localparam int ACC_DIGITS = WORD_DIGITS + 1,
    localparam int MAG_W      = 4 * ACC_DIGITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       op,
    input  logic             ld_sign,
    input  logic [MAG_W-1:0] ld_mag,
    input  logic [CNT_W-1:0] shl_cnt,
    input  logic [CNT_W-1:0] shr_cnt,
    output logic             acc_sign,
    output logic [MAG_W-1:0] acc_mag,
    output logic             acc_neg
);
    import dacc_pkg::*;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
    } acc_t;

    acc_t             acc_q, acc_d;
    acc_t             sel;
    logic [MAG_W-1:0] ld_clean;
    logic [MAG_W-1:0] shl_mag;
    logic [MAG_W-1:0] shift_mag;
    logic             norm_sign;
    acc_op_e          op_e;

    assign op_e = acc_op_e'(op);

    bcd_load_clamp #(.DIGITS(ACC_DIGITS)) u_clamp (
        .raw_mag   (ld_mag),
        .clean_mag (ld_clean)
    );

    bcd_digit_shift #(.DIGITS(ACC_DIGITS), .CNT_W(CNT_W), .SHIFT_LEFT(1'b1)) u_shl (
        .din  (acc_q.mag),
        .cnt  (shl_cnt),
        .dout (shl_mag)
    );

    bcd_digit_shift #(.DIGITS(ACC_DIGITS), .CNT_W(CNT_W), .SHIFT_LEFT(1'b0)) u_shr (
        .din  (shl_mag),
        .cnt  (shr_cnt),
        .dout (shift_mag)
    );

    always_comb begin
        sel = acc_q;
        if (en) begin
            unique case (op_e)
                OP_LOAD:  sel = '{sign: ld_sign, mag: ld_clean};
                OP_SHIFT: sel = '{sign: acc_q.sign, mag: shift_mag};
                default:  sel = acc_q;
            endcase
        end
    end

    sign_mag_norm #(.MAG_W(MAG_W)) u_norm (
        .sign_in  (sel.sign),
        .mag_in   (sel.mag),
        .sign_out (norm_sign)
    );

    always_comb begin
        acc_d      = sel;
        acc_d.sign = norm_sign;
        if (rst) begin
            acc_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        acc_q <= acc_d;
    end

    assign acc_sign = acc_q.sign;
    assign acc_mag  = acc_q.mag;
    assign acc_neg  = acc_q.sign;

endmodule

// File: rtl/dec_accum_chk.sv
module dec_accum_chk #(
    parameter int ACC_DIGITS = 4,
    parameter int MAG_W      = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [1:0]       op,
    input logic             ld_sign,
    input logic [MAG_W-1:0] ld_mag,
    input logic             acc_sign,
    input logic [MAG_W-1:0] acc_mag,
    input logic             acc_neg
);
    function automatic logic all_bcd(input logic [MAG_W-1:0] m);
        for (int i = 0; i < ACC_DIGITS; i++) begin
            if (m[4*i +: 4] > 4'd9) return 1'b0;
        end
        return 1'b1;
    endfunction

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (acc_mag == '0 && !acc_sign && !acc_neg)); // R1

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (en && op == 2'b01 && all_bcd(ld_mag) && ld_mag != '0)
        |=> (acc_mag == $past(ld_mag) && acc_sign == $past(ld_sign))); // R2

    AST_DIGITS_BCD: assert property (@(posedge clk) disable iff (rst)
        en |=> all_bcd(acc_mag)); // R3

    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_sign |-> (acc_mag != '0)); // R8

    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
        acc_neg == acc_sign); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en || op == 2'b00 || op == 2'b11)
        |=> ($stable(acc_mag) && $stable(acc_sign))); // R10

endmodule

bind dec_accum dec_accum_chk #(.ACC_DIGITS(ACC_DIGITS), .MAG_W(MAG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .op       (op),
    .ld_sign  (ld_sign),
    .ld_mag   (ld_mag),
    .acc_sign (acc_sign),
    .acc_mag  (acc_mag),
    .acc_neg  (acc_neg)
);

// File: tb/sim_dec_accum.sv
`timescale 1ns/1ps
module sim_dec_accum;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [1:0]  op  = 2'b00;
    logic        ld_sign = 1'b0;
    logic [15:0] ld_mag  = '0;
    logic [3:0]  shl_cnt = '0;
    logic [3:0]  shr_cnt = '0;
    logic        acc_sign;
    logic [15:0] acc_mag;
    logic        acc_neg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dec_accum u0 (
        .clk(clk), .rst(rst), .en(en), .op(op),
        .ld_sign(ld_sign), .ld_mag(ld_mag),
        .shl_cnt(shl_cnt), .shr_cnt(shr_cnt),
        .acc_sign(acc_sign), .acc_mag(acc_mag), .acc_neg(acc_neg)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        s;
        logic [15:0] mag;
        logic [3:0]  l;
        logic [3:0]  r;
        logic        es;
        logic [15:0] em;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'b01, 1'b0, 16'h0123, 4'd0, 4'd0,  1'b0, 16'h0123, 8'd2},  // R2
        '{2'b10, 1'b0, 16'h0000, 4'd1, 4'd0,  1'b0, 16'h1230, 8'd4},  // R4
        '{2'b10, 1'b0, 16'h0000, 4'd1, 4'd0,  1'b0, 16'h2300, 8'd4},  // R4 top digit lost
        '{2'b01, 1'b1, 16'h0457, 4'd0, 4'd0,  1'b1, 16'h0457, 8'd9},  // R9
        '{2'b10, 1'b0, 16'h0000, 4'd0, 4'd1,  1'b1, 16'h0045, 8'd5},  // R5
        '{2'b10, 1'b0, 16'h0000, 4'd0, 4'd2,  1'b0, 16'h0000, 8'd8},  // R8
        '{2'b01, 1'b0, 16'h9999, 4'd0, 4'd0,  1'b0, 16'h9999, 8'd2},  // R2
        '{2'b10, 1'b0, 16'h0000, 4'd0, 4'd0,  1'b0, 16'h9999, 8'd4},  // R4 zero count
        '{2'b01, 1'b0, 16'h0123, 4'd0, 4'd0,  1'b0, 16'h0123, 8'd2},
        '{2'b10, 1'b0, 16'h0000, 4'd2, 4'd3,  1'b0, 16'h0002, 8'd6},  // R6
        '{2'b01, 1'b1, 16'h0123, 4'd0, 4'd0,  1'b1, 16'h0123, 8'd2},
        '{2'b10, 1'b0, 16'h0000, 4'd4, 4'd0,  1'b0, 16'h0000, 8'd7},  // R7
        '{2'b01, 1'b1, 16'h0678, 4'd0, 4'd0,  1'b1, 16'h0678, 8'd2},
        '{2'b10, 1'b0, 16'h0000, 4'd0, 4'd15, 1'b0, 16'h0000, 8'd7},  // R7
        '{2'b01, 1'b1, 16'h0000, 4'd0, 4'd0,  1'b0, 16'h0000, 8'd8},  // R8
        '{2'b01, 1'b0, 16'h0A5F, 4'd0, 4'd0,  1'b0, 16'h0959, 8'd3},  // R3
        '{2'b01, 1'b1, 16'h0250, 4'd0, 4'd0,  1'b1, 16'h0250, 8'd2},
        '{2'b11, 1'b0, 16'h1111, 4'd1, 4'd1,  1'b1, 16'h0250, 8'd10}, // R10
        '{2'b00, 1'b0, 16'h2222, 4'd2, 4'd0,  1'b1, 16'h0250, 8'd10}, // R10
        '{2'b01, 1'b1, 16'h0810, 4'd0, 4'd0,  1'b1, 16'h0810, 8'd2},
        '{2'b10, 1'b0, 16'h0000, 4'd1, 4'd1,  1'b1, 16'h0810, 8'd6},  // R6
        '{2'b10, 1'b0, 16'h0000, 4'd3, 4'd3,  1'b0, 16'h0000, 8'd6},  // R6
        '{2'b01, 1'b1, 16'hF000, 4'd0, 4'd0,  1'b1, 16'h9000, 8'd3},  // R3
        '{2'b10, 1'b0, 16'h0000, 4'd0, 4'd3,  1'b1, 16'h0009, 8'd5}   // R5
    };

    task automatic check(input string req, input logic es, input logic [15:0] em);
        n_checks++;
        if (acc_sign !== es || acc_mag !== em || acc_neg !== es) begin
            n_fail++;
            $display("FAIL %s: got sign=%b mag=%h neg=%b, expected sign=%b mag=%h neg=%b",
                     req, acc_sign, acc_mag, acc_neg, es, em, es);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        tick();
        tick();
        check("R1 reset state", 1'b0, 16'h0000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            en      = 1'b1;
            op      = VECS[i].op;
            ld_sign = VECS[i].s;
            ld_mag  = VECS[i].mag;
            shl_cnt = VECS[i].l;
            shr_cnt = VECS[i].r;
            tick();
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].es, VECS[i].em);
        end

        // R10: enable low blocks a load
        en = 1'b0; op = 2'b01; ld_sign = 1'b0; ld_mag = 16'h0777;
        tick();
        check("R10 enable low", 1'b1, 16'h0009);

        // R10: enable low blocks a shift
        op = 2'b10; shl_cnt = 4'd2; shr_cnt = 4'd0;
        tick();
        check("R10 enable low shift", 1'b1, 16'h0009);

        // R1: reset wins over a simultaneous load
        en = 1'b1; op = 2'b01; ld_sign = 1'b1; ld_mag = 16'h0321; rst = 1'b1;
        tick();
        check("R1 reset priority", 1'b0, 16'h0000);
        rst = 1'b0;

        // R4: left shift keeps negative sign and drops the overflow digit
        op = 2'b01; ld_sign = 1'b1; ld_mag = 16'h5432;
        tick();
        check("R2 load full width", 1'b1, 16'h5432);
        op = 2'b10; shl_cnt = 4'd2; shr_cnt = 4'd0;
        tick();
        check("R4 left by two", 1'b1, 16'h3200);

        en = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule